// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block is the register front end of a raw NAND flash controller. Software programs a flash command byte, a flash address byte, a buffer/chip-select register and two configuration words through a 16-bit register port. It then writes a single operation bit into the operation register. The block runs exactly one bus phase on a simplified NAND pin interface: a command latch, an address latch, a page program from its internal byte buffer, a page read into that buffer, an ID read or a status read.

Once the strobes of the phase are over and the flash reports ready, a sticky completion flag rises in bit 15 of the operation register. An interrupt line follows that flag unless a mask bit in the main configuration word is set. A self-clearing soft-reset request, a chip-enable bit, a two-bit active-chip field and a pages-per-erase-block code are also decoded. Software fills and drains the byte buffer through an auto-incrementing data window. The phases are separate, so a full page operation is a sequence of register writes made by software.

Top module: `nand_op_seq`

## Requirements
- R1: After reset every register reads 0, the completion flag and `irq` are 0, `nf_ce_n`, `nf_we_n` and `nf_re_n` are 1, and `nf_cle`, `nf_ale` and `nf_dq_oe` are 0.
- R2: The registers at offsets 0 (flash command), 1 (flash address), 2 (buffer/chip select), 3 (general config), 4 (main config) and 6 (spare size) read back the full 16-bit value last written, as long as main-config bit 6 is written as 0.
- R3: Writing the operation register (offset 5) with only bit 0 set produces one `nf_we_n` low pulse with `nf_cle`=1, `nf_ale`=0 and `nf_dq_o` equal to bits 7:0 of the command register.
- R4: Writing only operation bit 1 produces one `nf_we_n` pulse with `nf_ale`=1, `nf_cle`=0 and `nf_dq_o` equal to bits 7:0 of the address register.
- R5: Writing only operation bit 2 (program) drives all BUF_LEN buffer bytes on `nf_dq_o`, index 0 first, one `nf_we_n` pulse each, with `nf_cle` and `nf_ale` low.
- R6: Writing only operation bit 3 (page read), bit 4 (ID read) or bit 5 (status read) produces BUF_LEN, ID_LEN or 1 `nf_re_n` pulses. The byte on `nf_dq_i` during pulse k is stored at buffer index k, higher buffer bytes are left unchanged, and no `nf_we_n` pulse occurs.
- R7: Operation bit 15 (completion) becomes 1 only after the last strobe of the phase, and only once `nf_rb_n` is 1. While `nf_rb_n` stays 0 it stays 0, and the operation register shows the running operation bit in bits 5:0.
- R8: Completion is sticky. A write to the operation register with bit 15 at 0 clears it, and a write with bit 15 at 1 leaves it set.
- R9: `irq` is 1 exactly when completion is 1 and main-config bit 4 (mask) is 0. A masked completion still reads as 1 in operation bit 15.
- R10: An operation write while a phase is running, or with zero or several of bits 5:0 set, starts no phase and leaves the running phase unchanged.
- R11: Writing main-config bit 6 as 1 starts a soft reset. The bit reads 1, then clears itself after RST_CYC cycles. Meanwhile completion is cleared and operation writes start nothing.
- R12: `nf_ce_n` is the inverse of main-config bit 7, and `nf_cs` equals bits 6:5 of the buffer/chip-select register.
- R13: `pages_per_blk` is 32, 64, 128 or 256 for main-config bits 10:9 equal to 0, 1, 2 or 3.
- R14: Offset 7 is a byte window into the buffer. Each write stores bits 7:0 and each read pulse (`reg_rd`) returns a byte, and both advance a pointer that wraps at BUF_LEN. A write to offset 2 or the start of a phase resets the pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Read strobe; advances the data window pointer |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Completion interrupt, level |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cs | output | 2 | Active chip index |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_o | output | 8 | Data to flash |
| nf_dq_oe | output | 1 | Output enable for `nf_dq_o` |
| nf_dq_i | input | 8 | Data from flash |
| nf_rb_n | input | 1 | Flash ready (1) / busy (0) |
| pages_per_blk | output | 9 | Decoded pages per erase block |

## Verification
The hardest state to reach from the ports is a second operation write that lands while a phase is still in progress. With a ready flash, a phase lasts only a few cycles. The bench therefore holds `nf_rb_n` low, so the phase stays parked after its strobes. It issues the competing write in that window and only then releases ready, after which it checks that exactly one strobe of the first kind reached the pins. Soft reset is checked the same way. An operation write sent inside the reset window must leave the strobe count at zero, and the reset bit must have cleared itself after the window.

// File: rtl/nos_pkg.sv
package nos_pkg;

   typedef enum logic [2:0] {
      OPK_NONE,
      OPK_CMD,
      OPK_ADR,
      OPK_PROG,
      OPK_READ,
      OPK_ID,
      OPK_STAT
   } op_kind_e;

   // register offsets
   localparam logic [3:0] RA_CMD   = 4'd0;
   localparam logic [3:0] RA_ADR   = 4'd1;
   localparam logic [3:0] RA_BUF   = 4'd2;
   localparam logic [3:0] RA_CFG0  = 4'd3;
   localparam logic [3:0] RA_CFG1  = 4'd4;
   localparam logic [3:0] RA_OP    = 4'd5;
   localparam logic [3:0] RA_SPARE = 4'd6;
   localparam logic [3:0] RA_DATA  = 4'd7;

   // main config bit positions
   localparam int unsigned C1_MASK = 4;
   localparam int unsigned C1_SRST = 6;
   localparam int unsigned C1_CE   = 7;
   localparam int unsigned C1_PPB  = 9;

   localparam int unsigned OP_DONE = 15;

   function automatic op_kind_e op_from_bits(input logic [5:0] b);
      op_kind_e k;
      k = OPK_NONE;
      if (b[0]) k = OPK_CMD;
      else if (b[1]) k = OPK_ADR;
      else if (b[2]) k = OPK_PROG;
      else if (b[3]) k = OPK_READ;
      else if (b[4]) k = OPK_ID;
      else if (b[5]) k = OPK_STAT;
      return k;
   endfunction

endpackage

// File: rtl/nos_pagebuf.sv
module nos_pagebuf #(
   parameter int unsigned BUF_LEN = 8,
   localparam int unsigned IW = $clog2(BUF_LEN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          a_we,
   input  logic [IW-1:0] a_idx,
   input  logic [7:0]    a_wdata,
   output logic [7:0]    a_rdata,
   input  logic          b_we,
   input  logic [IW-1:0] b_idx,
   input  logic [7:0]    b_wdata,
   output logic [7:0]    b_rdata
);

   logic [BUF_LEN-1:0][7:0] mem;

   for (genvar gi = 0; gi < BUF_LEN; gi++) begin : g_byte
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (a_we && a_idx == IW'(gi)) begin
            q <= a_wdata;
         end else if (b_we && b_idx == IW'(gi)) begin
            q <= b_wdata;
         end
      end
      assign mem[gi] = q;
   end

   assign a_rdata = mem[a_idx];
   assign b_rdata = mem[b_idx];

endmodule

// File: rtl/nos_phase.sv
module nos_phase
   import nos_pkg::*;
#(
   parameter int unsigned BUF_LEN    = 8,
   parameter int unsigned ID_LEN     = 4,
   parameter int unsigned STROBE_CYC = 2,
   localparam int unsigned IW = $clog2(BUF_LEN),
   localparam int unsigned TW = $clog2(STROBE_CYC + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          abort,
   input  logic          start,
   input  op_kind_e      start_kind,
   input  logic [7:0]    cmd_byte,
   input  logic [7:0]    adr_byte,
   input  logic          rb_n,
   input  logic [7:0]    dq_i,
   input  logic [7:0]    buf_rdata,
   output logic          busy,
   output logic          finish,
   output logic          we_n,
   output logic          re_n,
   output logic          cle,
   output logic          ale,
   output logic [7:0]    dq_o,
   output logic          dq_oe,
   output logic          pb_we,
   output logic [IW-1:0] pb_idx,
   output logic [7:0]    pb_wdata
);

   typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH, PH_WAIT} ph_state_e;

   ph_state_e     st;
   op_kind_e      kind_q;
   logic [IW-1:0] idx, last;
   logic [TW-1:0] tmr;
   logic [7:0]    byte_q;
   logic          is_rd, active;

   assign is_rd  = (kind_q == OPK_READ) || (kind_q == OPK_ID) || (kind_q == OPK_STAT);
   assign active = (st == PH_LOW) || (st == PH_HIGH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= PH_IDLE;
         kind_q <= OPK_NONE;
         idx    <= '0;
         last   <= '0;
         tmr    <= '0;
         byte_q <= '0;
      end else if (abort) begin
         st <= PH_IDLE;
      end else begin
         unique case (st)
            PH_IDLE: if (start) begin
               st     <= PH_LOW;
               kind_q <= start_kind;
               idx    <= '0;
               tmr    <= TW'(STROBE_CYC - 1);
               byte_q <= (start_kind == OPK_CMD) ? cmd_byte : adr_byte;
               unique case (start_kind)
                  OPK_PROG, OPK_READ: last <= IW'(BUF_LEN - 1);
                  OPK_ID:             last <= IW'(ID_LEN - 1);
                  default:            last <= '0;
               endcase
            end
            PH_LOW: begin
               if (tmr == '0) st <= PH_HIGH;
               else           tmr <= tmr - 1'b1;
            end
            PH_HIGH: begin
               if (idx == last) begin
                  st <= PH_WAIT;
               end else begin
                  idx <= idx + 1'b1;
                  tmr <= TW'(STROBE_CYC - 1);
                  st  <= PH_LOW;
               end
            end
            PH_WAIT: if (rb_n) st <= PH_IDLE;
            default: st <= PH_IDLE;
         endcase
      end
   end

   assign busy     = (st != PH_IDLE);
   assign finish   = (st == PH_WAIT) && rb_n && !abort;
   assign we_n     = !((st == PH_LOW) && !is_rd);
   assign re_n     = !((st == PH_LOW) && is_rd);
   assign cle      = active && (kind_q == OPK_CMD);
   assign ale      = active && (kind_q == OPK_ADR);
   assign dq_oe    = active && !is_rd;
   assign dq_o     = !dq_oe ? 8'h00 : (kind_q == OPK_PROG) ? buf_rdata : byte_q;
   assign pb_we    = (st == PH_LOW) && (tmr == '0) && is_rd && !abort;
   assign pb_idx   = idx;
   assign pb_wdata = dq_i;

   // R3 R4: the two latch enables are never raised together
   p_latch_excl_r3: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale));
   // R5 R6: a phase strobes either the write or the read line, never both
   p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n) !(!we_n && !re_n));
   // R6: captures into the buffer only happen on the read strobe
   p_capture_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n) pb_we |-> !re_n);

endmodule

// File: rtl/nos_regfile.sv
module nos_regfile
   import nos_pkg::*;
#(
   parameter int unsigned BUF_LEN = 8,
   parameter int unsigned RST_CYC = 16,
   localparam int unsigned IW = $clog2(BUF_LEN),
   localparam int unsigned RW = $clog2(RST_CYC + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [3:0]    reg_addr,
   input  logic [15:0]   reg_wdata,
   output logic [15:0]   reg_rdata,
   input  logic          phase_busy,
   input  logic          phase_finish,
   input  logic [7:0]    hbuf_rdata,
   output logic          hbuf_we,
   output logic [IW-1:0] hbuf_idx,
   output logic [7:0]    hbuf_wdata,
   output logic          start,
   output op_kind_e      start_kind,
   output logic [7:0]    cmd_byte,
   output logic [7:0]    adr_byte,
   output logic          soft_rst,
   output logic          done,
   output logic          irq_mask,
   output logic          ce_en,
   output logic [1:0]    cs_sel,
   output logic [1:0]    ppb_code
);

   logic [15:0]   r_cmd, r_adr, r_buf, r_cfg0, r_cfg1, r_spare;
   logic [5:0]    r_act;
   logic          r_done;
   logic [IW-1:0] ptr;
   logic [RW-1:0] rst_cnt;
   logic          op_wr, cfg1_wr, data_rd;

   assign op_wr   = reg_wr && (reg_addr == RA_OP);
   assign cfg1_wr = reg_wr && (reg_addr == RA_CFG1);
   assign data_rd = reg_rd && (reg_addr == RA_DATA);
   assign soft_rst = r_cfg1[C1_SRST];

   assign start      = op_wr && $onehot(reg_wdata[5:0]) && !phase_busy && !soft_rst;
   assign start_kind = op_from_bits(reg_wdata[5:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_cmd   <= '0;
         r_adr   <= '0;
         r_buf   <= '0;
         r_cfg0  <= '0;
         r_cfg1  <= '0;
         r_spare <= '0;
         r_act   <= '0;
         r_done  <= 1'b0;
         ptr     <= '0;
         rst_cnt <= '0;
      end else begin
         // soft reset countdown, overridden by a fresh main config write below
         if (soft_rst) begin
            if (rst_cnt == '0) r_cfg1[C1_SRST] <= 1'b0;
            else               rst_cnt <= rst_cnt - 1'b1;
         end
         if (data_rd) ptr <= ptr + 1'b1;
         if (reg_wr) begin
            unique case (reg_addr)
               RA_CMD:   r_cmd   <= reg_wdata;
               RA_ADR:   r_adr   <= reg_wdata;
               RA_BUF: begin
                  r_buf <= reg_wdata;
                  ptr   <= '0;
               end
               RA_CFG0:  r_cfg0  <= reg_wdata;
               RA_CFG1: begin
                  r_cfg1 <= reg_wdata;
                  if (reg_wdata[C1_SRST]) rst_cnt <= RW'(RST_CYC - 1);
               end
               RA_SPARE: r_spare <= reg_wdata;
               RA_DATA:  ptr     <= ptr + 1'b1;
               default: ;
            endcase
         end
         // completion flag: soft reset wins, then finishing, then software clear
         if (soft_rst)                                r_done <= 1'b0;
         else if (phase_finish)                       r_done <= 1'b1;
         else if (op_wr && !reg_wdata[OP_DONE])       r_done <= 1'b0;
         // running operation readback
         if (phase_finish || soft_rst) begin
            r_act <= '0;
         end else if (start) begin
            r_act <= reg_wdata[5:0];
            ptr   <= '0;
         end
      end
   end

   assign hbuf_we    = reg_wr && (reg_addr == RA_DATA) && !phase_busy;
   assign hbuf_idx   = ptr;
   assign hbuf_wdata = reg_wdata[7:0];

   assign cmd_byte = r_cmd[7:0];
   assign adr_byte = r_adr[7:0];
   assign done     = r_done;
   assign irq_mask = r_cfg1[C1_MASK];
   assign ce_en    = r_cfg1[C1_CE];
   assign cs_sel   = r_buf[6:5];
   assign ppb_code = r_cfg1[C1_PPB +: 2];

   always_comb begin
      unique case (reg_addr)
         RA_CMD:   reg_rdata = r_cmd;
         RA_ADR:   reg_rdata = r_adr;
         RA_BUF:   reg_rdata = r_buf;
         RA_CFG0:  reg_rdata = r_cfg0;
         RA_CFG1:  reg_rdata = r_cfg1;
         RA_OP:    reg_rdata = {r_done, 9'b0, r_act};
         RA_SPARE: reg_rdata = r_spare;
         RA_DATA:  reg_rdata = {8'h00, hbuf_rdata};
         default:  reg_rdata = 16'h0000;
      endcase
   end

   // R10: the running operation readback never changes while a phase is in flight
   p_act_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (|r_act && !phase_finish && !soft_rst) |=> $stable(r_act));
   // R11: the reset request bit falls once its window has run out
   p_srst_selfclear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst && rst_cnt == '0 && !cfg1_wr) |=> !soft_rst);
   // R11: completion is never raised while a soft reset is pending
   p_srst_no_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst && !cfg1_wr) |=> !r_done);

endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq
   import nos_pkg::*;
#(
   parameter int unsigned BUF_LEN    = 8,
   parameter int unsigned ID_LEN     = 4,
   parameter int unsigned STROBE_CYC = 2,
   parameter int unsigned RST_CYC    = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [3:0]  reg_addr,
   input  logic [15:0] reg_wdata,
   output logic [15:0] reg_rdata,
   output logic        irq,
   output logic        nf_ce_n,
   output logic [1:0]  nf_cs,
   output logic        nf_cle,
   output logic        nf_ale,
   output logic        nf_we_n,
   output logic        nf_re_n,
   output logic [7:0]  nf_dq_o,
   output logic        nf_dq_oe,
   input  logic [7:0]  nf_dq_i,
   input  logic        nf_rb_n,
   output logic [8:0]  pages_per_blk
);

   localparam int unsigned IW = $clog2(BUF_LEN);

   if (BUF_LEN < 2 || (BUF_LEN & (BUF_LEN - 1)) != 0)
      $error("BUF_LEN must be a power of two of at least 2");
   if (ID_LEN < 1 || ID_LEN > BUF_LEN)
      $error("ID_LEN must lie in 1..BUF_LEN");
   if (STROBE_CYC < 1)
      $error("STROBE_CYC must be at least 1");
   if (RST_CYC < 1)
      $error("RST_CYC must be at least 1");

   logic          start, soft_rst, done, irq_mask, ce_en;
   logic          phase_busy, phase_finish;
   op_kind_e      start_kind;
   logic [7:0]    cmd_byte, adr_byte;
   logic [1:0]    ppb_code;
   logic          hbuf_we, pb_we;
   logic [IW-1:0] hbuf_idx, pb_idx;
   logic [7:0]    hbuf_wdata, hbuf_rdata, pb_wdata, pb_rdata;

   nos_regfile #(.BUF_LEN(BUF_LEN), .RST_CYC(RST_CYC)) u_regs (
      .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
      .phase_busy, .phase_finish, .hbuf_rdata, .hbuf_we, .hbuf_idx, .hbuf_wdata,
      .start, .start_kind, .cmd_byte, .adr_byte, .soft_rst, .done,
      .irq_mask, .ce_en, .cs_sel(nf_cs), .ppb_code
   );

   nos_phase #(.BUF_LEN(BUF_LEN), .ID_LEN(ID_LEN), .STROBE_CYC(STROBE_CYC)) u_phase (
      .clk, .rst_n, .abort(soft_rst), .start, .start_kind, .cmd_byte, .adr_byte,
      .rb_n(nf_rb_n), .dq_i(nf_dq_i), .buf_rdata(pb_rdata),
      .busy(phase_busy), .finish(phase_finish),
      .we_n(nf_we_n), .re_n(nf_re_n), .cle(nf_cle), .ale(nf_ale),
      .dq_o(nf_dq_o), .dq_oe(nf_dq_oe),
      .pb_we, .pb_idx, .pb_wdata
   );

   nos_pagebuf #(.BUF_LEN(BUF_LEN)) u_buf (
      .clk, .rst_n,
      .a_we(pb_we), .a_idx(pb_idx), .a_wdata(pb_wdata), .a_rdata(pb_rdata),
      .b_we(hbuf_we), .b_idx(hbuf_idx), .b_wdata(hbuf_wdata), .b_rdata(hbuf_rdata)
   );

   assign irq           = done && !irq_mask;
   assign nf_ce_n       = !ce_en;
   assign pages_per_blk = 9'd32 << ppb_code;

   // R7: completion only rises after a cycle in which the flash reported ready
   p_ready_before_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(nf_rb_n));
   // R10: with no phase in flight both strobes rest high
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !phase_busy |-> (nf_we_n && nf_re_n));

endmodule

// File: tb/nand_op_seq_bench.sv
`timescale 1ns/1ps
module nand_op_seq_bench;

   localparam int BUF_LEN = 8;
   localparam int ID_LEN  = 4;
   localparam int RST_CYC = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        irq, nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
   logic [1:0]  nf_cs;
   logic [7:0]  nf_dq_o;
   logic [7:0]  nf_dq_i = '0;
   logic        nf_rb_n = 1'b1;
   logic [8:0]  pages_per_blk;

   always #4 clk = ~clk;

   nand_op_seq #(.BUF_LEN(BUF_LEN), .ID_LEN(ID_LEN), .STROBE_CYC(2), .RST_CYC(RST_CYC))
   u_nand_op_seq (.*);

   int checks = 0, errors = 0;
   bit finished = 0;

   // pin monitor: write strobes logged on their rising edge
   bit         mon_en = 0;
   int         wcount = 0, rcount = 0;
   logic [7:0] wlog_dq [32];
   logic       wlog_cle [32];
   logic       wlog_ale [32];
   always @(posedge nf_we_n) begin
      #1;
      if (mon_en && wcount < 32) begin
         wlog_dq[wcount]  = nf_dq_o;
         wlog_cle[wcount] = nf_cle;
         wlog_ale[wcount] = nf_ale;
      end
      if (mon_en) wcount++;
   end

   // flash model: presents the next byte when the read strobe falls
   logic [7:0] fl_data [16];
   int         fl_k = 0;
   always @(negedge nf_re_n) begin
      if (mon_en) begin
         nf_dq_i <= fl_data[fl_k];
         fl_k++;
         rcount++;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic rd_data(output logic [7:0] d);
      @(negedge clk);
      reg_addr = 4'd7; reg_rd = 1'b1;
      #1 d = reg_rdata[7:0];
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic run_op(input logic [15:0] bits);
      logic [15:0] v;
      wr(4'd5, bits);
      for (int t = 0; t < 300; t++) begin
         rd(4'd5, v);
         if (v[15]) break;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // register vectors: {offset, write value, expected readback}
   localparam logic [35:0] REG_VEC [6] = '{
      {4'd0, 16'h01A5, 16'h01A5},
      {4'd1, 16'h0C3C, 16'h0C3C},
      {4'd2, 16'h0067, 16'h0067},
      {4'd3, 16'hBEEF, 16'hBEEF},
      {4'd4, 16'h0E90, 16'h0E90},
      {4'd6, 16'h0040, 16'h0040}
   };

   initial begin
      #(8 * 150000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      logic [7:0]  b;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(4'd5, v);  chk("R1 op reg", v, 16'h0000);
      rd(4'd4, v);  chk("R1 cfg1", v, 16'h0000);
      chk("R1 irq", irq, 0);
      chk("R1 strobes/enables", {nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale, nf_dq_oe}, 6'b111000);

      // R2 readback table
      foreach (REG_VEC[i]) begin
         wr(REG_VEC[i][35:32], REG_VEC[i][31:16]);
         rd(REG_VEC[i][35:32], v);
         chk("R2 readback", v, REG_VEC[i][15:0]);
      end
      // R12 R13 from the programmed values
      chk("R12 ce_n", nf_ce_n, 0);
      chk("R12 cs", nf_cs, 2'd3);
      chk("R13 ppb code 3", pages_per_blk, 256);
      wr(4'd4, 16'h0280);
      chk("R13 ppb code 1", pages_per_blk, 64);
      wr(4'd4, 16'h0480);
      chk("R13 ppb code 2", pages_per_blk, 128);
      wr(4'd4, 16'h0080);
      chk("R13 ppb code 0", pages_per_blk, 32);
      wr(4'd4, 16'h0000);
      chk("R12 ce_n off", nf_ce_n, 1);
      wr(4'd4, 16'h0680);
      mon_en = 1;

      // R3 command latch
      wcount = 0;
      run_op(16'h0001);
      idle(2);
      chk("R3 strobe count", wcount, 1);
      chk("R3 dq", wlog_dq[0], 8'hA5);
      chk("R3 cle/ale", {wlog_cle[0], wlog_ale[0]}, 2'b10);
      rd(4'd5, v);  chk("R7 done set", v, 16'h8000);
      chk("R9 irq unmasked", irq, 1);

      // R8 clear
      wr(4'd5, 16'h0000);
      rd(4'd5, v);  chk("R8 cleared", v, 16'h0000);
      chk("R9 irq follows clear", irq, 0);

      // R4 address latch
      wcount = 0;
      run_op(16'h0002);
      idle(2);
      chk("R4 strobe count", wcount, 1);
      chk("R4 dq", wlog_dq[0], 8'h3C);
      chk("R4 cle/ale", {wlog_cle[0], wlog_ale[0]}, 2'b01);

      // R8 keep with bit 15 set; R10 multi-bit write starts nothing
      wr(4'd5, 16'h8003);
      idle(10);
      rd(4'd5, v);  chk("R8 kept", v, 16'h8000);
      chk("R10 multi-bit no strobe", wcount, 1);
      wr(4'd5, 16'h8000);
      idle(6);
      chk("R10 zero-bit no strobe", wcount, 1);

      // R9 mask
      wr(4'd4, 16'h0690);
      chk("R9 masked irq", irq, 0);
      rd(4'd5, v);  chk("R9 masked flag visible", v, 16'h8000);
      wr(4'd4, 16'h0680);
      chk("R9 unmask irq", irq, 1);

      // R14 fill buffer, R5 program
      wr(4'd2, 16'h0067);
      for (int i = 0; i < BUF_LEN; i++) wr(4'd7, 16'h0010 + 16'(3 * i));
      wcount = 0;
      run_op(16'h0004);
      idle(2);
      chk("R5 strobe count", wcount, BUF_LEN);
      for (int i = 0; i < BUF_LEN; i++) begin
         chk("R5 program byte", wlog_dq[i], 8'h10 + 8'(3 * i));
         chk("R5 no latch", {wlog_cle[i], wlog_ale[i]}, 2'b00);
      end

      // R6 page read
      for (int i = 0; i < BUF_LEN; i++) fl_data[i] = 8'hC0 + 8'(i);
      fl_k = 0; wcount = 0; rcount = 0;
      run_op(16'h0008);
      chk("R6 read strobes", rcount, BUF_LEN);
      chk("R6 no write strobes", wcount, 0);
      wr(4'd2, 16'h0067);
      for (int i = 0; i < BUF_LEN; i++) begin
         rd_data(b);
         chk("R6 read byte / R14 window", b, 8'hC0 + 8'(i));
      end
      rd_data(b);
      chk("R14 pointer wraps", b, 8'hC0);

      // R6 ID read
      for (int i = 0; i < ID_LEN; i++) fl_data[i] = 8'h50 + 8'(i);
      fl_k = 0; rcount = 0;
      run_op(16'h0010);
      chk("R6 id strobes", rcount, ID_LEN);
      wr(4'd2, 16'h0067);
      for (int i = 0; i <= ID_LEN; i++) begin
         rd_data(b);
         chk("R6 id byte", b, (i < ID_LEN) ? 8'h50 + 8'(i) : 8'hC0 + 8'(i));
      end

      // R6 status read
      fl_data[0] = 8'hE0; fl_k = 0; rcount = 0;
      run_op(16'h0020);
      chk("R6 status strobes", rcount, 1);
      wr(4'd2, 16'h0067);
      rd_data(b);  chk("R6 status byte", b, 8'hE0);
      rd_data(b);  chk("R6 status leaves next", b, 8'h51);

      // R7 busy flash holds completion; R10 competing write while busy
      nf_rb_n = 1'b0;
      wcount = 0;
      wr(4'd5, 16'h0001);
      idle(40);
      rd(4'd5, v);  chk("R7 held while busy", v, 16'h0001);
      wr(4'd5, 16'h0002);
      idle(5);
      rd(4'd5, v);  chk("R10 running op unchanged", v, 16'h0001);
      nf_rb_n = 1'b1;
      idle(4);
      rd(4'd5, v);  chk("R7 done after ready", v, 16'h8000);
      chk("R10 single strobe", wcount, 1);
      chk("R10 strobe was command", wlog_cle[0], 1);

      // R11 soft reset
      wr(4'd4, 16'h06C0);
      rd(4'd4, v);  chk("R11 request visible", v, 16'h06C0);
      rd(4'd5, v);  chk("R11 done cleared", v, 16'h0000);
      wcount = 0;
      wr(4'd5, 16'h0001);
      idle(RST_CYC + 4);
      chk("R11 op ignored in reset", wcount, 0);
      rd(4'd4, v);  chk("R11 self clear", v, 16'h0680);
      run_op(16'h0001);
      idle(2);
      chk("R11 operation after reset", wcount, 1);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule